// File: doc/BRIEF.md
# UART Fractional Baud-Rate Timing Core

This core generates the 16x oversampling tick for a serial port from a divisor that has a 16-bit whole part and a 6-bit fraction counted in 64ths. A fraction f means that over any 64 consecutive tick periods, f of them are stretched by one clock. The stretched periods are chosen by a 6-bit phase accumulator, so the average period equals the programmed divisor. A programmed fraction is the fractional part of the divisor times 64, rounded to the nearest integer. For example, a divisor of 10.8507 is entered as whole part 10 and fraction 54.

Software reaches the registers over a simple word-addressed bus with 16-bit data. Divisor writes only land in the programmed registers. The generator runs from working copies, which are refreshed by a write to the line-control register. The refresh takes effect only while the core is disabled and no frame is moving. The expected sequence is:

1. Disable the core.
2. Write the whole divisor.
3. Write the fractional divisor.
4. Write line control.
5. Enable the core.

Clearing the enable does not cut a frame short. The frame in flight finishes, and then nothing new starts. The core contains a one-entry transmitter and a one-entry receiver, each 8N1, so that the tick and the disable behaviour can be seen at the pins.

Top module: `uart_frac_core`

## Requirements
- R1: After reset, the registers read as follows: data, whole divisor, fractional divisor and line control read 0; control (0x030) reads 0x300, with transmit enable at bit 8, receive enable at bit 9 and master enable at bit 0 clear; flag (0x018) reads 0x90.
- R2: The registers store what is written. The whole divisor (0x024) keeps 16 bits, the fractional divisor (0x028) keeps bits 5:0, and line control (0x02C) keeps bits 7:0, including word-length codes other than 11 in bits 6:5.
- R3: While ticks run continuously, the spacing between two consecutive ticks on `baud_tick_o` is D or D+1 clocks, where D is the working whole divisor.
- R4: Over any 64 consecutive tick intervals, the clock total is exactly 64*D + F, where F is the working fraction.
- R5: A line-control write copies the programmed divisors into the working copies only while the master enable is clear and no frame is active. Writes to the divisor registers alone leave the tick timing unchanged.
- R6: With a working whole divisor of zero, there are no ticks and no transmission starts. A byte waiting in the holding register is sent once a nonzero divisor is latched and the core is enabled.
- R7: A transmitted frame has these parts, in order: a low start bit, 8 data bits LSB first, and a high stop bit. Each bit lasts 16 ticks. `txd_o` idles high.
- R8: A received frame with a valid stop bit is stored for reading at data (0x000) and sets flag bit 6 (receive full) while clearing bit 4 (receive empty). Reading data sets bit 4 again.
- R9: Writing data (0x000) while the holding register is empty loads it and clears flag bit 7 (transmit empty). Flag bit 3 (busy) is high while a frame is shifting out.
- R10: Clearing the master enable in mid-frame lets the current frame finish intact. While the core is disabled, no new frame starts, and a byte written then stays held.
- R11: With the transmit enable (control bit 8) clear, a held byte is not sent. It is sent once the bit is set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Bus access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 for a write, 0 for a read |
| bus_addr_i | input | 12 | Byte offset of the register |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, valid in the cycle of the strobe |
| txd_o | output | 1 | Serial transmit line |
| rxd_i | input | 1 | Serial receive line |
| baud_tick_o | output | 1 | 16x oversampling tick, one clock wide |

## Verification
Two situations are hard to reach from the ports:

- **Accumulator phase.** The fraction's effect only shows across 64 periods, and the accumulator may start at any phase. The bench sweeps every fraction value for several small whole divisors and sums 64 measured intervals, which cancels the unknown starting phase.
- **Disable in mid-frame.** Here the enable must drop while both shifters are active. With the transmit line looped back to the receive line, the bench uses a slow divisor, clears the enable about a hundred clocks into the frame, and then requires the receiver to deliver the byte whole. It then holds a second byte while the core is disabled and watches the line stay idle.

// File: rtl/uart_frac_pkg.sv
package uart_frac_pkg;
  localparam int unsigned ADDR_W = 12;

  localparam logic [ADDR_W-1:0] A_DATA = 12'h000;
  localparam logic [ADDR_W-1:0] A_FLAG = 12'h018;
  localparam logic [ADDR_W-1:0] A_IDIV = 12'h024;
  localparam logic [ADDR_W-1:0] A_FDIV = 12'h028;
  localparam logic [ADDR_W-1:0] A_LINE = 12'h02C;
  localparam logic [ADDR_W-1:0] A_CTRL = 12'h030;

  localparam int unsigned C_EN  = 0;
  localparam int unsigned C_TXE = 8;
  localparam int unsigned C_RXE = 9;

  localparam int unsigned F_BUSY  = 3;
  localparam int unsigned F_RXEMP = 4;
  localparam int unsigned F_TXFUL = 5;
  localparam int unsigned F_RXFUL = 6;
  localparam int unsigned F_TXEMP = 7;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;
endpackage

// File: rtl/uart_frac_baud.sv
module uart_frac_baud #(
  parameter int unsigned IDIV_W = 16,
  parameter int unsigned FRAC_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [IDIV_W-1:0] idiv_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic              tick_o
);
  logic [IDIV_W-1:0] cnt_q;
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   sum;
  logic [IDIV_W-1:0] reload;
  logic              active;

  assign active = run_i && (idiv_i != '0);
  assign sum    = {1'b0, acc_q} + {1'b0, frac_i};
  // carry out of the phase accumulator stretches the next period by one clock
  assign reload = idiv_i - IDIV_W'(1) + IDIV_W'(sum[FRAC_W]);
  assign tick_o = active && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else if (!active) begin
      cnt_q <= idiv_i - IDIV_W'(1);
      acc_q <= '0;
    end else if (cnt_q == '0) begin
      cnt_q <= reload;
      acc_q <= sum[FRAC_W-1:0];
    end else begin
      cnt_q <= cnt_q - IDIV_W'(1);
    end
  end

  logic [IDIV_W:0] gap_q;
  logic            seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (!active) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (tick_o) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else begin
      gap_q <= gap_q + 1'b1;
    end
  end

  // R3
  period_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && seen_q) |-> ((gap_q + 1'b1) == {1'b0, idiv_i} || gap_q == {1'b0, idiv_i}));
endmodule

// File: rtl/uart_frac_tx.sv
module uart_frac_tx #(
  parameter int unsigned OS     = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              tick_i,
  output logic              txd_o,
  output logic              busy_o
);
  localparam int unsigned OS_W  = $clog2(OS);
  localparam int unsigned BITS  = DATA_W + 2;
  localparam int unsigned BIT_W = $clog2(BITS);

  logic [BITS-1:0]  sh_q;
  logic [OS_W-1:0]  os_q;
  logic [BIT_W-1:0] bit_q;
  logic             busy_q, txd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      os_q   <= '0;
      bit_q  <= '0;
      busy_q <= 1'b0;
      txd_q  <= 1'b1;
    end else if (start_i && !busy_q) begin
      sh_q   <= {1'b1, data_i, 1'b0};
      os_q   <= '0;
      bit_q  <= '0;
      busy_q <= 1'b1;
      txd_q  <= 1'b0;
    end else if (busy_q && tick_i) begin
      if (os_q == OS_W'(OS - 1)) begin
        os_q <= '0;
        if (bit_q == BIT_W'(BITS - 1)) begin
          busy_q <= 1'b0;
          txd_q  <= 1'b1;
        end else begin
          bit_q <= bit_q + 1'b1;
          sh_q  <= sh_q >> 1;
          txd_q <= sh_q[1];
        end
      end else begin
        os_q <= os_q + 1'b1;
      end
    end
  end

  assign txd_o  = txd_q;
  assign busy_o = busy_q;

  // R7
  idle_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> txd_q);
  // R7
  frame_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> $past(tick_i));
endmodule

// File: rtl/uart_frac_rx.sv
module uart_frac_rx
  import uart_frac_pkg::*;
#(
  parameter int unsigned OS     = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rxd_i,
  input  logic              enable_i,
  input  logic              tick_i,
  output logic              busy_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned OS_W  = $clog2(OS);
  localparam int unsigned HALF  = OS / 2;
  localparam int unsigned BIT_W = $clog2(DATA_W);

  logic [1:0]        sync_q;
  logic              rxs;
  rx_state_e         state_q;
  logic [OS_W-1:0]   os_q;
  logic [BIT_W-1:0]  bit_q;
  logic [DATA_W-1:0] sh_q, data_q;
  logic              valid_q;

  assign rxs = sync_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[0], rxd_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      os_q    <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      case (state_q)
        RX_IDLE: if (enable_i && tick_i && !rxs) begin
          state_q <= RX_START;
          os_q    <= '0;
        end
        RX_START: if (tick_i) begin
          if (os_q == OS_W'(HALF - 1)) begin
            os_q    <= '0;
            bit_q   <= '0;
            state_q <= rxs ? RX_IDLE : RX_DATA;
          end else os_q <= os_q + 1'b1;
        end
        RX_DATA: if (tick_i) begin
          if (os_q == OS_W'(OS - 1)) begin
            os_q <= '0;
            sh_q <= {rxs, sh_q[DATA_W-1:1]};
            if (bit_q == BIT_W'(DATA_W - 1)) state_q <= RX_STOP;
            else bit_q <= bit_q + 1'b1;
          end else os_q <= os_q + 1'b1;
        end
        RX_STOP: if (tick_i) begin
          if (os_q == OS_W'(OS - 1)) begin
            os_q    <= '0;
            state_q <= RX_IDLE;
            if (rxs) begin
              valid_q <= 1'b1;
              data_q  <= sh_q;
            end
          end else os_q <= os_q + 1'b1;
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  assign busy_o  = (state_q != RX_IDLE);
  assign valid_o = valid_q;
  assign data_o  = data_q;

  // R8
  rx_frame_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> $past(state_q == RX_STOP && tick_i));
endmodule

// File: rtl/uart_frac_core.sv
module uart_frac_core
  import uart_frac_pkg::*;
#(
  parameter int unsigned IDIV_W = 16,
  parameter int unsigned FRAC_W = 6,
  parameter int unsigned LINE_W = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OS     = 16,
  parameter int unsigned BUS_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [BUS_W-1:0]  bus_wdata_i,
  output logic [BUS_W-1:0]  bus_rdata_o,
  output logic              txd_o,
  input  logic              rxd_i,
  output logic              baud_tick_o
);
  logic [IDIV_W-1:0] idiv_q, idiv_w;
  logic [FRAC_W-1:0] frac_q, frac_w;
  logic [LINE_W-1:0] line_q;
  logic              en_q, txe_q, rxe_q;
  logic [DATA_W-1:0] tx_hold_q, rx_data;
  logic              tx_full_q, rx_full_q;
  logic              tx_busy, rx_busy, rx_valid, tick, run, idle, tx_start;
  logic              wr, rd;

  assign wr       = bus_sel_i && bus_we_i;
  assign rd       = bus_sel_i && !bus_we_i;
  assign idle     = !en_q && !tx_busy && !rx_busy;
  assign run      = en_q || tx_busy || rx_busy;
  assign tx_start = en_q && txe_q && tx_full_q && !tx_busy && (idiv_w != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idiv_q <= '0;
      frac_q <= '0;
      line_q <= '0;
      idiv_w <= '0;
      frac_w <= '0;
      en_q   <= 1'b0;
      txe_q  <= 1'b1;
      rxe_q  <= 1'b1;
    end else if (wr) begin
      case (bus_addr_i)
        A_IDIV: idiv_q <= bus_wdata_i[IDIV_W-1:0];
        A_FDIV: frac_q <= bus_wdata_i[FRAC_W-1:0];
        A_LINE: begin
          line_q <= bus_wdata_i[LINE_W-1:0];
          if (idle) begin
            idiv_w <= idiv_q;
            frac_w <= frac_q;
          end
        end
        A_CTRL: begin
          en_q  <= bus_wdata_i[C_EN];
          txe_q <= bus_wdata_i[C_TXE];
          rxe_q <= bus_wdata_i[C_RXE];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_hold_q <= '0;
      tx_full_q <= 1'b0;
      rx_full_q <= 1'b0;
    end else begin
      if (tx_start) tx_full_q <= 1'b0;
      else if (wr && bus_addr_i == A_DATA && !tx_full_q) begin
        tx_hold_q <= bus_wdata_i[DATA_W-1:0];
        tx_full_q <= 1'b1;
      end
      if (rx_valid) rx_full_q <= 1'b1;
      else if (rd && bus_addr_i == A_DATA) rx_full_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      A_DATA: bus_rdata_o = BUS_W'(rx_data);
      A_FLAG: begin
        bus_rdata_o[F_BUSY]  = tx_busy;
        bus_rdata_o[F_RXEMP] = !rx_full_q;
        bus_rdata_o[F_TXFUL] = tx_full_q;
        bus_rdata_o[F_RXFUL] = rx_full_q;
        bus_rdata_o[F_TXEMP] = !tx_full_q;
      end
      A_IDIV: bus_rdata_o = BUS_W'(idiv_q);
      A_FDIV: bus_rdata_o = BUS_W'(frac_q);
      A_LINE: bus_rdata_o = BUS_W'(line_q);
      A_CTRL: begin
        bus_rdata_o[C_EN]  = en_q;
        bus_rdata_o[C_TXE] = txe_q;
        bus_rdata_o[C_RXE] = rxe_q;
      end
      default: ;
    endcase
  end

  uart_frac_baud #(.IDIV_W(IDIV_W), .FRAC_W(FRAC_W)) u_baud (
    .clk_i, .rst_ni, .run_i(run), .idiv_i(idiv_w), .frac_i(frac_w), .tick_o(tick)
  );

  uart_frac_tx #(.OS(OS), .DATA_W(DATA_W)) u_tx (
    .clk_i, .rst_ni, .start_i(tx_start), .data_i(tx_hold_q), .tick_i(tick),
    .txd_o, .busy_o(tx_busy)
  );

  uart_frac_rx #(.OS(OS), .DATA_W(DATA_W)) u_rx (
    .clk_i, .rst_ni, .rxd_i, .enable_i(en_q && rxe_q), .tick_i(tick),
    .busy_o(rx_busy), .valid_o(rx_valid), .data_o(rx_data)
  );

  assign baud_tick_o = tick;

  // R5
  latch_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(idiv_w) |-> $past(!en_q && !tx_busy && !rx_busy));
  // R6
  start_div_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_busy) |-> $past(idiv_w != '0 && en_q && txe_q));
  // R10
  hold_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !tx_busy) |=> !tx_busy);
endmodule

// File: tb/uart_frac_core_bench.sv
module uart_frac_core_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        txd, tick;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  localparam logic [11:0] DATA = 12'h000, FLAG = 12'h018, IDIV = 12'h024,
                          FDIV = 12'h028, LINE = 12'h02C, CTRL = 12'h030;

  always #2 clk = ~clk;

  uart_frac_core u_uart_frac_core (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .txd_o(txd), .rxd_i(txd), .baud_tick_o(tick)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk); sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [15:0] d);
    @(negedge clk); sel = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk); sel = 1'b0;
  endtask

  task automatic configure(input int i, input int f);
    wr(CTRL, 16'h0300); wr(IDIV, 16'(i)); wr(FDIV, 16'(f));
    wr(LINE, 16'h0060); wr(CTRL, 16'h0301);
  endtask

  // R3 R4: 64 intervals after first seen tick
  task automatic measure(input string tag, input int i, input int f);
    int n, sum, gap; bit each_ok;
    n = 0;
    while (!tick && n < 200000) begin @(negedge clk); n++; end
    sum = 0; each_ok = 1'b1;
    for (int k = 0; k < 64; k++) begin
      gap = 0;
      do begin @(negedge clk); gap++; end while (!tick && gap < 100000);
      if (gap != i && gap != i + 1) each_ok = 1'b0;
      sum += gap;
    end
    chk({tag, " R3 interval D or D+1"}, int'(each_ok), 1);
    chk({tag, " R4 64-interval total"}, sum, 64 * i + f);
  endtask

  task automatic quiet(input int n, output bit ok);
    ok = 1'b1;
    for (int k = 0; k < n; k++) begin @(negedge clk); if (txd !== 1'b1) ok = 1'b0; end
  endtask

  task automatic wait_rx(output bit got);
    logic [15:0] v;
    got = 1'b0;
    for (int k = 0; k < 3000 && !got; k++) begin rd(FLAG, v); got = v[6]; end
  endtask

  task automatic expect_byte(input string tag, input int b);
    bit got; logic [15:0] v;
    wait_rx(got);
    chk({tag, " frame received"}, int'(got), 1);
    rd(DATA, v);
    chk(tag, int'(v), b);
  endtask

  initial begin
    logic [15:0] v; bit ok; int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1
    rd(DATA, v); chk("R1 data", v, 0);
    rd(IDIV, v); chk("R1 idiv", v, 0);
    rd(FDIV, v); chk("R1 fdiv", v, 0);
    rd(LINE, v); chk("R1 line", v, 0);
    rd(CTRL, v); chk("R1 ctrl", v, 16'h0300);
    rd(FLAG, v); chk("R1 flag", v, 16'h0090);
    // R2
    wr(IDIV, 16'hBEEF); rd(IDIV, v); chk("R2 idiv", v, 16'hBEEF);
    wr(FDIV, 16'hFFFF); rd(FDIV, v); chk("R2 fdiv", v, 16'h003F);
    wr(LINE, 16'h01F4); rd(LINE, v); chk("R2 line 8 bits", v, 16'h00F4);
    wr(LINE, 16'h0040); rd(LINE, v); chk("R2 line short word", v, 16'h0040);
    wr(CTRL, 16'h0201); rd(CTRL, v); chk("R2 ctrl", v, 16'h0201);
    wr(CTRL, 16'h0300);
    // R3 R4 sweep
    foreach (n_list[j]) for (int f = 0; f < 64; f++) begin
      configure(n_list[j], f);
      measure($sformatf("d=%0d f=%0d", n_list[j], f), n_list[j], f);
    end
    // R5
    configure(3, 0); measure("R5 base", 3, 0);
    wr(IDIV, 16'd7); wr(FDIV, 16'd10);
    rd(IDIV, v); chk("R5 programmed idiv", v, 7);
    measure("R5 no latch", 3, 0);
    wr(LINE, 16'h0060); measure("R5 enabled line write", 3, 0);
    wr(CTRL, 16'h0300); wr(LINE, 16'h0060); wr(CTRL, 16'h0301);
    measure("R5 latched", 7, 10);
    // R6
    configure(0, 0);
    n = 0;
    for (int k = 0; k < 300; k++) begin @(negedge clk); if (tick) n++; end
    chk("R6 no ticks", n, 0);
    wr(DATA, 16'h00AA); quiet(2000, ok);
    chk("R6 line idle", int'(ok), 1);
    rd(FLAG, v); chk("R6 held byte flags", v & 16'h00A8, 16'h0020);
    configure(1, 32); expect_byte("R6 released byte", 16'hAA);
    // R7 R8 R9 exhaustive bytes
    configure(1, 0);
    for (int b = 0; b < 256; b++) begin
      wr(DATA, 16'(b));
      if (b == 0) begin rd(FLAG, v); chk("R9 busy and empty", v & 16'h0088, 16'h0088); end
      expect_byte($sformatf("R7 byte %0d", b), b);
      if (b == 0) begin rd(FLAG, v); chk("R8 rx empty after read", v & 16'h0050, 16'h0010); end
    end
    // R9 holding register full
    configure(4, 0);
    wr(DATA, 16'h0011); wr(DATA, 16'h0022);
    rd(FLAG, v); chk("R9 second byte held", v & 16'h00A8, 16'h0028);
    expect_byte("R9 first", 16'h11); expect_byte("R9 second", 16'h22);
    // R10
    wr(DATA, 16'h005A);
    repeat (100) @(negedge clk);
    wr(CTRL, 16'h0300);
    rd(FLAG, v); chk("R10 still busy", v & 16'h0008, 16'h0008);
    expect_byte("R10 frame completes", 16'h5A);
    repeat (200) @(negedge clk);
    wr(DATA, 16'h0033); quiet(1500, ok);
    chk("R10 no start while disabled", int'(ok), 1);
    rd(FLAG, v); chk("R10 byte held", v & 16'h0088, 16'h0000);
    wr(CTRL, 16'h0301); expect_byte("R10 sent after enable", 16'h33);
    // R11
    wr(CTRL, 16'h0201);
    wr(DATA, 16'h0077); quiet(1500, ok);
    chk("R11 txe clear blocks", int'(ok), 1);
    wr(CTRL, 16'h0301); expect_byte("R11 sent after txe", 16'h77);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  int n_list[3] = '{1, 2, 5};

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule